// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit performs one bit-addressed operation per accepted request on an 8-bit operand. The caller presents the operand byte, a bit number, an operation code and the current carry flag. One clock edge later the unit returns the modified byte with a write-back strobe, and it keeps registered copies of the carry (C) and zero (Z) flags. Address generation and the memory access around it belong to the caller.

There are three groups of operations. The first sets, clears or flips a bit. The second moves a bit into the flags: a test into Z, and a plain or inverted load into C. The third works between a bit and the carry: a store of C into the bit, plain or inverted, and a merge of the bit into C by AND, OR or XOR, each of these also with the bit inverted. Only operations that change the byte raise the write-back strobe. The caller stores the returned byte to memory when that strobe is high and feeds the registered carry back as the next request's carry input.

Top module: `bitop_unit`

## Requirements
- R1: After reset, `result_byte`, `wr_stb`, `flag_c` and `flag_z` are all 0.
- R2: Only the low 3 bits of `bit_num` select the bit, through the mask 1 shifted left by that value. Bit 3 of `bit_num` has no effect.
- R3: Codes 0 (set), 1 (clear) and 2 (flip) force the addressed bit to 1, force it to 0 or invert it. The other seven bits are returned unchanged and `wr_stb` is raised.
- R4: Code 3 (test) sets `flag_z` to 1 when the addressed bit is 0 and to 0 otherwise. It raises no write-back and leaves `flag_c` unchanged.
- R5: Code 4 copies the addressed bit into `flag_c` and code 5 copies its complement. Neither raises a write-back.
- R6: Code 6 writes `carry_in` into the addressed bit and code 7 writes its complement. All other bits are kept and `wr_stb` is raised.
- R7: Codes 8/9 give C = carry_in AND bit (or AND NOT bit), codes 10/11 the same with OR, and codes 12/13 the same with XOR. None raises a write-back.
- R8: A flag not named by the accepted operation keeps its value. `flag_z` changes only on code 3. `flag_c` changes only on codes 4, 5 and 8 to 13.
- R9: `wr_stb` is high for exactly the one cycle after each accepted modifying operation. `result_byte` only changes then. Codes 14 and 15, and cycles with `op_valid` low, change no output.
- R10: Results appear on the outputs one clock after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request accepted on this edge |
| op_code | input | 4 | Operation code (see R3 to R7) |
| bit_num | input | 4 | Bit number; bit 3 is ignored |
| data_in | input | 8 | Operand byte |
| carry_in | input | 1 | Current carry flag |
| result_byte | output | 8 | Byte to write back |
| wr_stb | output | 1 | Write-back strobe, one cycle |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
The bench sends requests with bit 3 of the bit number set. A unit that decoded all four bits would build an empty mask and change nothing, or would alias onto the wrong bit. Inverted stores and inverted logic forms are paired with both carry values, so a swapped polarity flips C or the stored bit. Requests with reserved codes and idle cycles come between writes: a unit that strobed on them, or left the strobe high for two cycles, would duplicate a store. Tests come right after carry operations and the other way round, so a unit that let a flag follow the wrong operation shows a moved Z or C.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [3:0] {
    BOP_SET  = 4'd0,
    BOP_CLR  = 4'd1,
    BOP_FLIP = 4'd2,
    BOP_TEST = 4'd3,
    BOP_LDC  = 4'd4,
    BOP_LDCN = 4'd5,
    BOP_STC  = 4'd6,
    BOP_STCN = 4'd7,
    BOP_ANDC = 4'd8,
    BOP_ANDN = 4'd9,
    BOP_ORC  = 4'd10,
    BOP_ORN  = 4'd11,
    BOP_XORC = 4'd12,
    BOP_XORN = 4'd13
  } bop_e;

  function automatic logic bop_writes(input logic [3:0] code);
    return (code == BOP_SET) || (code == BOP_CLR) || (code == BOP_FLIP) ||
           (code == BOP_STC) || (code == BOP_STCN);
  endfunction

  function automatic logic bop_touches_c(input logic [3:0] code);
    return (code == BOP_LDC) || (code == BOP_LDCN) ||
           ((code >= BOP_ANDC) && (code <= BOP_XORN));
  endfunction

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] mask
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] idx;
  assign idx = sel[IDX_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        code,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] mask,
  input  logic              carry,
  output logic [DATA_W-1:0] new_byte,
  output logic              sel_bit
);
  logic [DATA_W-1:0] cleared;

  assign sel_bit = |(operand & mask);
  assign cleared = operand & ~mask;

  always_comb begin
    new_byte = operand;
    case (code)
      BOP_SET:  new_byte = operand | mask;
      BOP_CLR:  new_byte = cleared;
      BOP_FLIP: new_byte = operand ^ mask;
      BOP_STC:  new_byte = cleared | (carry ? mask : '0);
      BOP_STCN: new_byte = cleared | (carry ? '0 : mask);
      default:  new_byte = operand;
    endcase
  end
endmodule

// File: rtl/bitop_flags.sv
module bitop_flags
  import bitop_pkg::*;
(
  input  logic [3:0] code,
  input  logic       sel_bit,
  input  logic       carry,
  input  logic       c_now,
  input  logic       z_now,
  output logic       c_next,
  output logic       z_next
);
  always_comb begin
    c_next = c_now;
    z_next = z_now;
    case (code)
      BOP_TEST: z_next = ~sel_bit;
      BOP_LDC:  c_next = sel_bit;
      BOP_LDCN: c_next = ~sel_bit;
      BOP_ANDC: c_next = carry & sel_bit;
      BOP_ANDN: c_next = carry & ~sel_bit;
      BOP_ORC:  c_next = carry | sel_bit;
      BOP_ORN:  c_next = carry | ~sel_bit;
      BOP_XORC: c_next = carry ^ sel_bit;
      BOP_XORN: c_next = carry ^ ~sel_bit;
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [SEL_W-1:0]  bit_num,
  input  logic [DATA_W-1:0] data_in,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result_byte,
  output logic              wr_stb,
  output logic              flag_c,
  output logic              flag_z
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] new_byte;
  logic              sel_bit;
  logic              c_next, z_next;
  logic              do_write;

  bitop_mask #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mask (
    .sel  (bit_num),
    .mask (mask)
  );

  bitop_datapath #(.DATA_W(DATA_W)) u_dp (
    .code     (op_code),
    .operand  (data_in),
    .mask     (mask),
    .carry    (carry_in),
    .new_byte (new_byte),
    .sel_bit  (sel_bit)
  );

  bitop_flags u_flags (
    .code    (op_code),
    .sel_bit (sel_bit),
    .carry   (carry_in),
    .c_now   (flag_c),
    .z_now   (flag_z),
    .c_next  (c_next),
    .z_next  (z_next)
  );

  assign do_write = op_valid && bop_writes(op_code);

  // next-state
  logic [DATA_W-1:0] byte_d;
  logic              stb_d, c_d, z_d;

  always_comb begin
    byte_d = result_byte;
    stb_d  = 1'b0;
    c_d    = flag_c;
    z_d    = flag_z;
    if (op_valid) begin
      c_d = c_next;
      z_d = z_next;
    end
    if (do_write) begin
      byte_d = new_byte;
      stb_d  = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result_byte <= '0;
      wr_stb      <= 1'b0;
      flag_c      <= 1'b0;
      flag_z      <= 1'b0;
    end else begin
      wr_stb <= stb_d;
      if (op_valid) begin
        flag_c <= c_d;
        flag_z <= z_d;
      end
      if (do_write) result_byte <= byte_d;
    end
  end

  // checks
  p_strobe_src_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_stb |-> ($past(op_valid) && bop_writes($past(op_code))));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(op_valid) |-> (!wr_stb && $stable(result_byte) && $stable(flag_c) && $stable(flag_z)));

  p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_stb |-> ($countones(result_byte ^ $past(data_in)) <= 1));

  p_z_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !($past(op_valid) && ($past(op_code) == BOP_TEST)) |-> $stable(flag_z));

  p_c_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !($past(op_valid) && bop_touches_c($past(op_code))) |-> $stable(flag_c));

  p_test_nowr_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(op_valid) && ($past(op_code) == BOP_TEST)) |-> !wr_stb);

endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [3:0] bit_num;
  logic [7:0] data_in;
  logic       carry_in;
  logic [7:0] result_byte;
  logic       wr_stb, flag_c, flag_z;

  always #5 clk = ~clk;

  bitop_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_num(bit_num), .data_in(data_in), .carry_in(carry_in),
    .result_byte(result_byte), .wr_stb(wr_stb), .flag_c(flag_c), .flag_z(flag_z)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic [7:0] e_byte;
  logic       e_wr, e_c, e_z;
  string      next_tag = "R1";
  string      cur_tag  = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      e_byte <= 8'h00; e_wr <= 1'b0; e_c <= 1'b0; e_z <= 1'b0;
      cur_tag <= "R1";
    end else begin
      e_wr <= 1'b0;
      cur_tag <= next_tag;
      if (op_valid) begin
        int s;
        logic b;
        s = int'(bit_num) % 8;
        b = data_in[s];
        case (int'(op_code))
          0: begin e_byte <= data_in | (8'd1 << s); e_wr <= 1'b1; end
          1: begin e_byte <= data_in & ~(8'd1 << s); e_wr <= 1'b1; end
          2: begin e_byte <= data_in ^ (8'd1 << s); e_wr <= 1'b1; end
          3: e_z <= (b == 1'b0);
          4: e_c <= b;
          5: e_c <= !b;
          6: begin e_byte <= (data_in & ~(8'd1 << s)) | (8'(carry_in) << s); e_wr <= 1'b1; end
          7: begin e_byte <= (data_in & ~(8'd1 << s)) | (8'(!carry_in) << s); e_wr <= 1'b1; end
          8:  e_c <= carry_in && b;
          9:  e_c <= carry_in && !b;
          10: e_c <= carry_in || b;
          11: e_c <= carry_in || !b;
          12: e_c <= carry_in != b;
          13: e_c <= carry_in != !b;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_tag, "result_byte", int'(result_byte), int'(e_byte));
    chk(cur_tag, "wr_stb",      int'(wr_stb),      int'(e_wr));
    chk(cur_tag, "flag_c",      int'(flag_c),      int'(e_c));
    chk(cur_tag, "flag_z",      int'(flag_z),      int'(e_z));
  endtask

  function automatic string tag_of(input int code);
    if (code <= 2) return "R3";
    if (code == 3) return "R4";
    if (code <= 5) return "R5";
    if (code <= 7) return "R6";
    if (code <= 13) return "R7";
    return "R9";
  endfunction

  // one request per cycle; compares the previous cycle's result first (R10)
  task automatic issue(input bit v, input int code, input int sel, input int d, input bit c, input string tag);
    @(negedge clk);
    compare();
    op_valid = v;
    op_code  = 4'(code);
    bit_num  = 4'(sel);
    data_in  = 8'(d);
    carry_in = c;
    next_tag = tag;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; bit_num = '0; data_in = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", "result_byte", int'(result_byte), 0);
    chk("R1", "wr_stb", int'(wr_stb), 0);
    chk("R1", "flag_c", int'(flag_c), 0);
    chk("R1", "flag_z", int'(flag_z), 0);
    rst_n = 1'b1;
    repeat (4) issue(0, 0, 0, 0, 0, "R1");

    // R3 set / clear / flip
    issue(1, 0, 5, 8'h00, 0, "R3");
    issue(1, 1, 0, 8'hFF, 0, "R3");
    issue(1, 2, 7, 8'h5A, 0, "R3");
    issue(1, 2, 6, 8'h5A, 1, "R3");
    // R2 bit 3 of bit_num ignored
    issue(1, 0, 12, 8'h00, 0, "R2");
    issue(1, 1, 15, 8'hFF, 0, "R2");
    issue(1, 3, 9, 8'h02, 0, "R2");
    // R4 test
    issue(1, 3, 3, 8'hF7, 0, "R4");
    issue(1, 3, 3, 8'h08, 1, "R4");
    // R5 loads
    issue(1, 4, 1, 8'h02, 0, "R5");
    issue(1, 5, 1, 8'h02, 0, "R5");
    issue(1, 5, 4, 8'h00, 0, "R5");
    // R6 stores, both carry values
    issue(1, 6, 2, 8'h00, 1, "R6");
    issue(1, 6, 2, 8'hFF, 0, "R6");
    issue(1, 7, 2, 8'h00, 1, "R6");
    issue(1, 7, 2, 8'h00, 0, "R6");
    // R7 logic with carry, all combinations
    for (int code = 8; code <= 13; code++)
      for (int bc = 0; bc < 4; bc++)
        issue(1, code, 6, (bc & 1) ? 8'h40 : 8'h00, bc[1], "R7");
    // R8 flags hold across other ops
    issue(1, 3, 0, 8'h00, 0, "R8");
    issue(1, 0, 0, 8'h00, 1, "R8");
    issue(1, 6, 1, 8'h00, 1, "R8");
    // R9 reserved codes and idle between writes
    issue(1, 0, 3, 8'h00, 0, "R9");
    issue(1, 14, 3, 8'hFF, 1, "R9");
    issue(1, 15, 0, 8'h00, 1, "R9");
    issue(0, 1, 3, 8'hFF, 1, "R9");
    issue(1, 2, 4, 8'h11, 0, "R9");
    issue(1, 2, 4, 8'h11, 0, "R9");
    issue(0, 0, 0, 8'h00, 0, "R9");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int code;
      code = int'($urandom_range(0, 15));
      issue(($urandom_range(0, 5) != 0), code, int'($urandom_range(0, 15)),
            int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), tag_of(code));
    end
    issue(0, 0, 0, 0, 0, "R10");
    issue(0, 0, 0, 0, 0, "R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule